// File: doc/BRIEF.md
# NRZ MAC Port Clock and Data Interface

This block sits on one port between a 10 Mb/s transceiver's decoded receive path and a MAC. It runs from a single 10 MHz clock. Each decoded receive bit and the carrier indication are registered once and passed on to the MAC. The receive clock is gated according to the selected receive-clock policy. Transmit data and transmit enable are captured from the MAC on the clock edge the mode calls for. After each transmitted frame, a fixed-length signal quality test pulse is raised on the collision output.

A small configuration word sets the behaviour: a 3-bit interface code, a receive idle-level bit and a tail-clock bit. The strap inputs load this word on every clock edge while reset is held. A later write through the register port is kept pending. It takes effect only when receive and transmit are both quiet, so a frame never sees its mode change in mid-flight.

The receive clock is produced by ANDing the source clock with an enable. That enable only changes while the source clock is low, so every pulse is whole.

Top module: `nrz_mac_port`

## Requirements
- R1: Interface codes are decoded as follows. Code 001 disables any post-carrier clock tail. Codes 010 and 011 capture transmit on the falling edge. Code 111 and every unlisted code (000, 100, 101, 110) capture on the rising edge. For every code except 001, tail bit 1 selects the TAIL_CLKS tail and tail bit 0 selects a free-running clock.
- R2: With code 001, mac_rxc_o pulses in a high phase only when mac_crs_o was high during the previous cycle. After a frame, exactly one pulse falls in high phases where mac_crs_o is already low, and that pulse clocks the last carrier bit.
- R3: With the tail selected (default TAIL_CLKS = 5), exactly TAIL_CLKS+1 pulses fall in high phases where mac_crs_o is low: the one that clocks the last carrier bit, then TAIL_CLKS extra. After that, mac_rxc_o stays low.
- R4: With tail bit 0 and code other than 001, mac_rxc_o pulses in every high phase, including while the carrier is idle.
- R5: enc_txd_o and enc_txe_o update on rising edges. In rising-capture modes they carry the MAC inputs present just before that rising edge. In falling-capture modes they carry the values captured at the falling edge before it.
- R6: The reset is synchronous and active low. While it is low, the configuration loads from the straps, and mac_crs_o, mac_col_o, enc_txd_o, enc_txe_o and mac_rxc_o are low. All-ones straps (the pulled-up default) select code 111, idle level high and the five-clock tail.
- R7: On the rising edge where enc_txe_o falls, mac_col_o rises and stays high for exactly SQE_CLKS cycles (default 10, 1 us at 10 MHz). A new fall restarts the count.
- R8: mac_col_o is high in every cycle where mac_crs_o and enc_txe_o are both high.
- R9: mac_crs_o and mac_rxd_o follow dec_crs_i and dec_rxd_i one cycle later. While mac_crs_o is low, mac_rxd_o equals the idle-level bit (1 means high).
- R10: A write (cfg_wr_i high at a rising edge) is held pending. It is applied at the first later rising edge where four conditions hold: mac_crs_o is low, the receive tail is finished, enc_txe_o is low and the test pulse is over. A newer unapplied write replaces an older one.
- R11: mac_rxc_o is low whenever clk_i is low, and its enable changes only during the low phase, so no partial pulse can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10 MHz source clock |
| rst_ni | input | 1 | Synchronous active-low reset; straps load while low |
| strap_code_i | input | 3 | Interface code loaded during reset |
| strap_idle_i | input | 1 | Receive idle level loaded during reset |
| strap_five_i | input | 1 | Tail-clock bit loaded during reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_code_i | input | 3 | Interface code to write |
| cfg_idle_i | input | 1 | Idle level to write |
| cfg_five_i | input | 1 | Tail-clock bit to write |
| dec_crs_i | input | 1 | Carrier from the receive decoder |
| dec_rxd_i | input | 1 | Decoded receive bit |
| mac_txd_i | input | 1 | Transmit bit from the MAC |
| mac_txe_i | input | 1 | Transmit enable from the MAC |
| mac_rxc_o | output | 1 | Gated receive clock to the MAC |
| mac_rxd_o | output | 1 | Receive data to the MAC |
| mac_crs_o | output | 1 | Carrier sense to the MAC |
| mac_col_o | output | 1 | Collision and test pulse to the MAC |
| enc_txd_o | output | 1 | Captured transmit bit toward the encoder |
| enc_txe_o | output | 1 | Captured transmit enable toward the encoder |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the end-of-transmit test pulse and a real collision. The bench drops transmit enable while a receive carrier is still present, so the test pulse starts during an ongoing collision. The second pair is a pending configuration write and the start of a new carrier. The bench issues a write while the port is idle and raises carrier on the very next cycle, so the deferred write is applied on the same edge the frame begins. In both cases a behavioural reference model predicts every output for every cycle, including the receive-clock pulse in each high phase, and the bench compares against it.

// File: rtl/nrz_port_pkg.sv
package nrz_port_pkg;

   localparam logic [2:0] CODE_RISE_TAIL = 3'b111;
   localparam logic [2:0] CODE_NO_TAIL   = 3'b001;
   localparam logic [2:0] CODE_FALL_A    = 3'b010;
   localparam logic [2:0] CODE_FALL_B    = 3'b011;

   typedef struct packed {
      logic [2:0] code;
      logic       idle_hi;
      logic       tail_five;
   } port_cfg_t;

   typedef enum logic [1:0] {
      GATE_NONE = 2'd0,
      GATE_TAIL = 2'd1,
      GATE_FREE = 2'd2
   } gate_pol_e;

   function automatic gate_pol_e gate_policy(port_cfg_t c);
      if (c.code == CODE_NO_TAIL) return GATE_NONE;
      return c.tail_five ? GATE_TAIL : GATE_FREE;
   endfunction

   function automatic logic tx_on_fall(logic [2:0] code);
      return (code == CODE_FALL_A) || (code == CODE_FALL_B);
   endfunction

endpackage

// File: rtl/nrz_cfg_reg.sv
module nrz_cfg_reg
   import nrz_port_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  port_cfg_t strap_i,
   input  logic      wr_i,
   input  port_cfg_t wdata_i,
   input  logic      quiet_i,
   output port_cfg_t cfg_o
);

   port_cfg_t cfg_q;
   port_cfg_t pend_q;
   logic      pend_v_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q    <= strap_i;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else begin
         if (pend_v_q && quiet_i) cfg_q <= pend_q;
         if (wr_i) begin
            pend_q   <= wdata_i;
            pend_v_q <= 1'b1;
         end else if (quiet_i) begin
            pend_v_q <= 1'b0;
         end
      end
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/nrz_rx_path.sv
module nrz_rx_path
   import nrz_port_pkg::*;
#(
   parameter int TAIL_CLKS = 5
)(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  port_cfg_t cfg_i,
   input  logic      crs_i,
   input  logic      rxd_i,
   output logic      crs_o,
   output logic      rxd_o,
   output logic      gate_o,
   output logic      busy_o
);

   localparam int TW = $clog2(TAIL_CLKS + 1);

   if (TAIL_CLKS < 1) begin : g_bad_tail
      $error("nrz_rx_path: TAIL_CLKS must be at least 1");
   end

   logic          crs_q;
   logic          rxd_q;
   logic [TW-1:0] tail_q;
   logic          tail_live;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         crs_q  <= 1'b0;
         rxd_q  <= 1'b0;
         tail_q <= '0;
      end else begin
         crs_q <= crs_i;
         rxd_q <= rxd_i;
         if (crs_q)          tail_q <= TW'(TAIL_CLKS);
         else if (tail_live) tail_q <= tail_q - TW'(1);
      end
   end

   assign tail_live = (tail_q != '0);

   always_comb begin
      unique case (gate_policy(cfg_i))
         GATE_NONE: gate_o = crs_q;
         GATE_TAIL: gate_o = crs_q | tail_live;
         default:   gate_o = 1'b1;
      endcase
   end

   assign crs_o  = crs_q;
   assign rxd_o  = crs_q ? rxd_q : cfg_i.idle_hi;
   assign busy_o = crs_q | tail_live;

   p_crs_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> crs_o == $past(crs_i));

   p_rxd_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && crs_o) |-> rxd_o == $past(rxd_i));

endmodule

// File: rtl/nrz_tx_path.sv
module nrz_tx_path #(
   parameter int SQE_CLKS = 10
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fall_i,
   input  logic txd_i,
   input  logic txe_i,
   input  logic crs_i,
   output logic txd_o,
   output logic txe_o,
   output logic col_o,
   output logic busy_o
);

   localparam int SW = $clog2(SQE_CLKS + 1);

   if (SQE_CLKS < 1) begin : g_bad_sqe
      $error("nrz_tx_path: SQE_CLKS must be at least 1");
   end

   logic          txd_n, txe_n;
   logic          txd_s, txe_s;
   logic          txd_q, txe_q;
   logic [SW-1:0] sqe_q;

   always_ff @(negedge clk_i) begin
      txd_n <= txd_i;
      txe_n <= txe_i;
   end

   assign txd_s = fall_i ? txd_n : txd_i;
   assign txe_s = fall_i ? txe_n : txe_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         txd_q <= 1'b0;
         txe_q <= 1'b0;
         sqe_q <= '0;
      end else begin
         txd_q <= txd_s;
         txe_q <= txe_s;
         if (txe_q && !txe_s)  sqe_q <= SW'(SQE_CLKS);
         else if (sqe_q != '0) sqe_q <= sqe_q - SW'(1);
      end
   end

   assign txd_o  = txd_q;
   assign txe_o  = txe_q;
   assign col_o  = (sqe_q != '0) | (crs_i & txe_q);
   assign busy_o = txe_q | (sqe_q != '0);

   p_tx_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(fall_i)) |-> txd_o == $past(txd_i));

   p_sqe_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(txe_o) |-> col_o);

endmodule

// File: rtl/nrz_rxc_gate.sv
module nrz_rxc_gate #(
   parameter bit LATCH_GATE = 1'b0
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic rxc_o
);

   logic en_hold;

   if (LATCH_GATE) begin : g_latch
      always_latch begin
         if (!clk_i) en_hold = en_i & rst_ni;
      end
   end else begin : g_negflop
      always_ff @(negedge clk_i) begin
         en_hold <= rst_ni ? en_i : 1'b0;
      end
   end

   assign rxc_o = clk_i & en_hold;

endmodule

// File: rtl/nrz_mac_port.sv
module nrz_mac_port
   import nrz_port_pkg::*;
#(
   parameter int TAIL_CLKS  = 5,
   parameter int SQE_CLKS   = 10,
   parameter bit LATCH_GATE = 1'b0
)(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] strap_code_i,
   input  logic       strap_idle_i,
   input  logic       strap_five_i,
   input  logic       cfg_wr_i,
   input  logic [2:0] cfg_code_i,
   input  logic       cfg_idle_i,
   input  logic       cfg_five_i,
   input  logic       dec_crs_i,
   input  logic       dec_rxd_i,
   input  logic       mac_txd_i,
   input  logic       mac_txe_i,
   output logic       mac_rxc_o,
   output logic       mac_rxd_o,
   output logic       mac_crs_o,
   output logic       mac_col_o,
   output logic       enc_txd_o,
   output logic       enc_txe_o
);

   port_cfg_t strap_cfg, wr_cfg, cfg;
   logic      rx_busy, tx_busy, rx_gate;

   assign strap_cfg = '{code: strap_code_i, idle_hi: strap_idle_i, tail_five: strap_five_i};
   assign wr_cfg    = '{code: cfg_code_i, idle_hi: cfg_idle_i, tail_five: cfg_five_i};

   nrz_cfg_reg u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strap_i (strap_cfg),
      .wr_i    (cfg_wr_i),
      .wdata_i (wr_cfg),
      .quiet_i (!rx_busy && !tx_busy),
      .cfg_o   (cfg)
   );

   nrz_rx_path #(.TAIL_CLKS(TAIL_CLKS)) u_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg),
      .crs_i  (dec_crs_i),
      .rxd_i  (dec_rxd_i),
      .crs_o  (mac_crs_o),
      .rxd_o  (mac_rxd_o),
      .gate_o (rx_gate),
      .busy_o (rx_busy)
   );

   nrz_tx_path #(.SQE_CLKS(SQE_CLKS)) u_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fall_i (tx_on_fall(cfg.code)),
      .txd_i  (mac_txd_i),
      .txe_i  (mac_txe_i),
      .crs_i  (mac_crs_o),
      .txd_o  (enc_txd_o),
      .txe_o  (enc_txe_o),
      .col_o  (mac_col_o),
      .busy_o (tx_busy)
   );

   nrz_rxc_gate #(.LATCH_GATE(LATCH_GATE)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (rx_gate),
      .rxc_o  (mac_rxc_o)
   );

   p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_busy || tx_busy) |=> $stable(cfg));

endmodule

// File: tb/test_nrz_mac_port.sv
module test_nrz_mac_port;

   localparam int CLK_PERIOD = 10;
   localparam int TAIL = 5;
   localparam int SQE  = 10;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic [2:0] strap_code_i = 3'b111;
   logic       strap_idle_i = 1'b1, strap_five_i = 1'b1;
   logic       cfg_wr_i = 1'b0;
   logic [2:0] cfg_code_i = 3'b000;
   logic       cfg_idle_i = 1'b0, cfg_five_i = 1'b0;
   logic       dec_crs_i = 1'b0, dec_rxd_i = 1'b0, mac_txd_i = 1'b0, mac_txe_i = 1'b0;
   logic       mac_rxc_o, mac_rxd_o, mac_crs_o, mac_col_o, enc_txd_o, enc_txe_o;

   int n_chk = 0, n_err = 0;
   string rtag = "R3", ctag = "R7", ttag = "R5";

   always #(CLK_PERIOD/2) clk = ~clk;

   nrz_mac_port #(.TAIL_CLKS(TAIL), .SQE_CLKS(SQE)) i_nrz_mac_port (
      .clk_i(clk), .rst_ni(rst_ni),
      .strap_code_i(strap_code_i), .strap_idle_i(strap_idle_i), .strap_five_i(strap_five_i),
      .cfg_wr_i(cfg_wr_i), .cfg_code_i(cfg_code_i), .cfg_idle_i(cfg_idle_i), .cfg_five_i(cfg_five_i),
      .dec_crs_i(dec_crs_i), .dec_rxd_i(dec_rxd_i), .mac_txd_i(mac_txd_i), .mac_txe_i(mac_txe_i),
      .mac_rxc_o(mac_rxc_o), .mac_rxd_o(mac_rxd_o), .mac_crs_o(mac_crs_o), .mac_col_o(mac_col_o),
      .enc_txd_o(enc_txd_o), .enc_txe_o(enc_txe_o)
   );

   // reference model state
   logic [2:0] m_code, p_code;
   bit m_idle, m_five, p_idle, p_five, m_pv;
   bit m_crs, m_rxd, m_txd, m_txe, m_rxc_exp, m_live;
   int m_tail, m_sqe;
   bit neg_txd, neg_txe, neg_rst;

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_n(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit model_gate();
      if (m_code == 3'b001) return m_crs;
      if (m_five) return m_crs || (m_tail > 0);
      return 1'b1;
   endfunction

   always @(negedge clk) begin
      neg_txd = mac_txd_i;
      neg_txe = mac_txe_i;
      neg_rst = rst_ni;
   end

   always @(posedge clk) begin : model
      bit fall, ntxd, ntxe, quiet;
      if (!rst_ni) begin
         m_code = strap_code_i; m_idle = strap_idle_i; m_five = strap_five_i;
         m_pv = 0; m_crs = 0; m_rxd = 0; m_txd = 0; m_txe = 0;
         m_tail = 0; m_sqe = 0; m_rxc_exp = 0; m_live = 0;
      end else begin
         m_rxc_exp = neg_rst ? model_gate() : 1'b0;
         fall  = (m_code == 3'b010) || (m_code == 3'b011);
         ntxd  = fall ? neg_txd : mac_txd_i;
         ntxe  = fall ? neg_txe : mac_txe_i;
         quiet = !m_crs && (m_tail == 0) && !m_txe && (m_sqe == 0);
         if (m_txe && !ntxe) m_sqe = SQE;
         else if (m_sqe > 0) m_sqe--;
         if (m_crs) m_tail = TAIL;
         else if (m_tail > 0) m_tail--;
         m_crs = dec_crs_i; m_rxd = dec_rxd_i; m_txd = ntxd; m_txe = ntxe;
         if (m_pv && quiet) begin
            m_code = p_code; m_idle = p_idle; m_five = p_five;
         end
         if (cfg_wr_i) begin
            p_code = cfg_code_i; p_idle = cfg_idle_i; p_five = cfg_five_i; m_pv = 1;
         end else if (quiet) m_pv = 0;
         m_live = 1;
      end
   end

   always @(posedge clk) begin
      #2;
      if (m_live && rst_ni) begin
         chk(mac_crs_o, m_crs, "R9 carrier");
         chk(mac_rxd_o, m_crs ? m_rxd : m_idle, "R9 receive data");
         chk(mac_col_o, (m_sqe > 0) || (m_crs && m_txe), ctag);
         chk(enc_txd_o, m_txd, ttag);
         chk(enc_txe_o, m_txe, ttag);
         chk(mac_rxc_o, m_rxc_exp, rtag);
      end
   end

   always @(negedge clk) begin
      #2;
      if (m_live) chk(mac_rxc_o, 1'b0, "R11 rxc low phase");
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic rx_frame(input int n);
      for (int i = 0; i < n; i++) begin
         dec_crs_i = 1'b1; dec_rxd_i = 1'($urandom); tick();
      end
      dec_crs_i = 1'b0; dec_rxd_i = 1'($urandom);
   endtask

   task automatic tx_frame(input int n);
      for (int i = 0; i < n; i++) begin
         mac_txe_i = 1'b1; mac_txd_i = 1'($urandom); tick();
      end
      mac_txe_i = 1'b0; mac_txd_i = 1'b0;
   endtask

   task automatic wr(input logic [2:0] code, input bit idle, input bit five);
      cfg_wr_i = 1'b1; cfg_code_i = code; cfg_idle_i = idle; cfg_five_i = five;
      tick();
      cfg_wr_i = 1'b0;
   endtask

   task automatic count_tail(input int exp, input string tag);
      int c = 0;
      repeat (20) begin
         @(posedge clk); #2;
         if (!mac_crs_o && mac_rxc_o) c++;
      end
      chk_n(c, exp, tag);
      tick();
   endtask

   task automatic count_all(input int exp, input string tag);
      int c = 0;
      repeat (20) begin
         @(posedge clk); #2;
         if (mac_rxc_o) c++;
      end
      chk_n(c, exp, tag);
      tick();
   endtask

   task automatic count_col(input int exp, input string tag);
      int c = 0;
      repeat (20) begin
         @(posedge clk); #2;
         if (mac_col_o) c++;
      end
      chk_n(c, exp, tag);
      tick();
   endtask

   task automatic edge_probe(input bit fall_exp, input string tag);
      mac_txe_i = 1'b0; mac_txd_i = 1'b0;
      tick(); tick();
      mac_txd_i = 1'b1;
      @(posedge clk); #2;
      chk(enc_txd_o, fall_exp ? 1'b0 : 1'b1, tag);
      tick();
      mac_txd_i = 1'b0;
      tick(); tick();
   endtask

   task automatic do_reset(input logic [2:0] code, input bit idle, input bit five);
      strap_code_i = code; strap_idle_i = idle; strap_five_i = five;
      dec_crs_i = 0; mac_txe_i = 0; mac_txd_i = 0;
      rst_ni = 1'b0;
      repeat (3) tick();
      chk(mac_crs_o, 1'b0, "R6 reset carrier");
      chk(mac_col_o, 1'b0, "R6 reset collision");
      chk(enc_txe_o, 1'b0, "R6 reset transmit enable");
      chk(enc_txd_o, 1'b0, "R6 reset transmit data");
      @(posedge clk); #2;
      chk(mac_rxc_o, 1'b0, "R6 reset receive clock");
      tick();
      rst_ni = 1'b1;
      tick();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      tick();
      do_reset(3'b111, 1'b1, 1'b1);
      rtag = "R6 default straps";
      rx_frame(8);
      count_tail(TAIL + 1, "R6 default straps give five-clock tail");
      rtag = "R3";
      rx_frame(12);
      count_tail(TAIL + 1, "R3 five-clock tail");

      ctag = "R7";
      tx_frame(6);
      count_col(SQE, "R7 SQE pulse length");

      // collision, then SQE starting while carrier is still present
      ctag = "R8";
      dec_crs_i = 1'b1;
      for (int i = 0; i < 4; i++) begin mac_txe_i = 1'b1; mac_txd_i = 1'($urandom); tick(); end
      mac_txe_i = 1'b0;
      repeat (3) tick();
      @(posedge clk); #2;
      chk(mac_col_o, 1'b1, "R8 collision overlapped by SQE");
      tick();
      dec_crs_i = 1'b0;
      repeat (20) tick();

      // write during a frame is deferred until quiet
      rtag = "R10";
      dec_crs_i = 1'b1; repeat (3) tick();
      wr(3'b001, 1'b0, 1'b1);
      repeat (3) tick();
      dec_crs_i = 1'b0;
      count_tail(TAIL + 1, "R10 frame keeps old tail after mid-frame write");
      rtag = "R2";
      rx_frame(5);
      count_tail(1, "R2 no tail in code 001");
      repeat (2) tick();

      // newer pending write replaces an older one
      rtag = "R10";
      dec_crs_i = 1'b1; tick();
      wr(3'b010, 1'b0, 1'b1);
      wr(3'b111, 1'b0, 1'b1);
      dec_crs_i = 1'b0;
      repeat (12) tick();
      edge_probe(1'b0, "R10 newer write replaces pending one");

      // falling capture, continuous clock, high idle level
      wr(3'b010, 1'b1, 1'b0);
      repeat (3) tick();
      rtag = "R4"; ttag = "R5";
      edge_probe(1'b1, "R5 falling-edge capture in code 010");
      count_all(20, "R4 continuous receive clock");
      @(posedge clk); #2;
      chk(mac_rxd_o, 1'b1, "R9 idle level high");
      tick();
      ctag = "R7";
      tx_frame(5);
      count_col(SQE, "R7 SQE in falling-capture mode");

      // unlisted code behaves as code 111
      rtag = "R1"; ttag = "R1";
      wr(3'b100, 1'b0, 1'b1);
      repeat (3) tick();
      edge_probe(1'b0, "R1 code 100 rising capture");
      rx_frame(4);
      count_tail(TAIL + 1, "R1 code 100 five-clock tail");
      wr(3'b011, 1'b0, 1'b1);
      repeat (3) tick();
      edge_probe(1'b1, "R1 code 011 falling capture");
      rx_frame(4);
      count_tail(TAIL + 1, "R1 code 011 five-clock tail");

      // write applied on the same edge a new carrier begins
      rtag = "R10";
      wr(3'b001, 1'b1, 1'b1);
      rx_frame(6);
      count_tail(1, "R10 write applied at carrier start");

      // non-default straps
      rtag = "R6"; ttag = "R6";
      do_reset(3'b011, 1'b0, 1'b0);
      edge_probe(1'b1, "R6 strap code 011 falling capture");
      count_all(20, "R6 strap continuous clock");
      @(posedge clk); #2;
      chk(mac_rxd_o, 1'b0, "R9 idle level low from strap");
      tick();
      rtag = "R4";
      rx_frame(7);
      repeat (10) tick();

      finish_run();
   end

endmodule